// File: doc/BRIEF.md
# Dual-Output Programmable Clock Divider

This block takes one fast master clock and derives two synchronous output clocks from it. Output 0 comes from its own prescaler, which divides the master clock by 1, 2, 4 or 8. Output 1 comes from a second, independent prescaler with the same choices. That prescaler feeds a ratio divider that can be set to any integer from 1 to 1025. All ratios arrive as parallel configuration inputs.

Each output passes through a gate. The gate opens or closes only while that output is low, so every high pulse that leaves the block has its full length. A mode input selects how the two control pins act. In the first mode they are per-output enables. In the second mode the enables come from configuration bits, and control pin 0 requests a powerdown. Powerdown silences both outputs and then holds all counters cleared. When the request is released, the counters restart from the start of a low phase.

Ratio and prescaler changes are taken in at the next terminal count of the counter they affect, so a period already in progress is never cut short. The control pins are asynchronous and pass through a synchronizer before use.

Top module: `dualclk_gen`

## Requirements
- R1: With prescaler 0 select s (2-bit, value s selects divide by 2^s) and s ≥ 1, output 0 is a square wave: 2^(s-1) master cycles high followed by 2^(s-1) master cycles low.
- R2: With prescaler 1 select s and effective ratio N ≥ 2, output 1 has a period of N·2^s master cycles. It is high for floor(N/2)·2^s cycles and low for the rest, so for an odd N the high phase is one prescaled cycle shorter than the low phase. With N = 1 and s ≥ 1, output 1 is the prescaled square wave, 2^(s-1) cycles high and 2^(s-1) cycles low.
- R3: The 11-bit ratio input is clamped: 0 acts as 1, and any value above 1025 acts as 1025.
- R4: Enabling or disabling an output never produces a high pulse shorter than the configured high time.
- R5: With mode input 0, control pin k enables output k, and the configuration enable bits have no effect.
- R6: With mode input 1, configuration enable bit k enables output k. Control pin 0 high requests powerdown, which drives both outputs low. Control pin 1 has no effect.
- R7: A disabled or powered-down output stays constantly low, within one output period plus the synchronizer delay.
- R8: Divide-by-1 passes the master clock through the gate. This applies to output 0 at select 0, and to output 1 at select 0 with effective ratio 1. The gate control is updated on the falling master edge.
- R9: While reset is asserted, both outputs are low.
- R10: After powerdown is released, an output's first rising edge comes within its low time plus six master cycles, and that first high pulse has its full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| ps0_sel | input | 2 | Prescaler 0 select, divide by 2^value |
| ps1_sel | input | 2 | Prescaler 1 select, divide by 2^value |
| ratio1 | input | 11 | Ratio for the divider on path 1 (clamped to 1..1025) |
| pin_mode | input | 1 | 0: pins are enables; 1: register enables, pin 0 is powerdown |
| reg_en | input | 2 | Configuration enable bits for outputs 0 and 1 |
| ctl_pin | input | 2 | Asynchronous control pins |
| clk_out0 | output | 1 | Gated output of path 0 |
| clk_out1 | output | 1 | Gated output of path 1 |

## Verification
A wrong counter or a wrong latched ratio shows at the ports within one output period, as a high or low run of the wrong length. A gate state that changes during a high phase shows as a short high pulse at the very next falling edge of that output. A powerdown that fails to clear the counters shows as a late or clipped first pulse after release. The bench therefore measures run lengths directly and compares each one against lengths computed from the ratio and prescaler settings.

// File: rtl/dualclk_pkg.sv
package dualclk_pkg;

    localparam int PS_SEL_W  = 2;
    localparam int RATIO_W   = 11;
    localparam int RATIO_MAX = 1025;

    typedef enum logic {
        CTL_AS_ENABLE    = 1'b0,
        CTL_AS_POWERDOWN = 1'b1
    } ctl_mode_e;

    // Everything one output gate needs from its path.
    typedef struct packed {
        logic lvl;     // ungated level, low phase first
        logic bypass;  // total ratio is 1: master clock passes through
        logic req;     // wanted gate state
    } gate_in_t;

    // Ratio clamp: 0 acts as 1, oversize values saturate.
    function automatic logic [RATIO_W-1:0] clamp_ratio(input logic [RATIO_W-1:0] r);
        if (r == '0)
            return RATIO_W'(1);
        if (r > RATIO_W'(RATIO_MAX))
            return RATIO_W'(RATIO_MAX);
        return r;
    endfunction

    // Number of low divider counts for ratio n (the larger half).
    function automatic logic [RATIO_W-1:0] low_span(input logic [RATIO_W-1:0] n);
        return n - (n >> 1);
    endfunction

endpackage

// File: rtl/dualclk_prescaler.sv
module dualclk_prescaler
    import dualclk_pkg::*;
#(
    parameter int SEL_W = PS_SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel_in,
    output logic [SEL_W-1:0] sel_q,
    output logic             tick,
    output logic             lvl
);
    localparam int CNT_W = (1 << SEL_W) - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = '0;
        lvl  = 1'b0;
        for (int i = 0; i < CNT_W; i++) begin
            mask[i] = (SEL_W'(i) < sel_q);
            if (sel_q == SEL_W'(i + 1))
                lvl = cnt_q[i];
        end
        tick = ((cnt_q & mask) == mask);
    end

    // The select is only taken in at a wrap, so a period is never cut.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            sel_q <= sel_in;
        end else if (tick) begin
            cnt_q <= '0;
            sel_q <= sel_in;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/dualclk_ratio_div.sv
module dualclk_ratio_div
    import dualclk_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               tick,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] cnt_q,
    output logic               lvl
);
    logic term;

    always_comb begin
        term = tick && (cnt_q == ratio_q - RATIO_W'(1));
        lvl  = (cnt_q >= low_span(ratio_q));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            ratio_q <= clamp_ratio(ratio_in);
        end else if (term) begin
            cnt_q   <= '0;
            ratio_q <= clamp_ratio(ratio_in);
        end else if (tick) begin
            cnt_q   <= cnt_q + RATIO_W'(1);
        end
    end

endmodule

// File: rtl/dualclk_out_gate.sv
module dualclk_out_gate
    import dualclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  gate_in_t gin,
    output logic     clk_out,
    output logic     gate_st,
    output logic     is_off
);
    logic g_q;
    logic o_q;
    logic g_lat;

    // Gate state may only move while the ungated level is low.
    always_ff @(posedge clk) begin
        if (rst) begin
            g_q <= 1'b0;
            o_q <= 1'b0;
        end else begin
            if (!gin.lvl)
                g_q <= gin.req;
            o_q <= gin.lvl & g_q;
        end
    end

    // Pass-through path: the falling edge starts the master low phase.
    always_ff @(negedge clk) begin
        if (rst)
            g_lat <= 1'b0;
        else
            g_lat <= gin.req;
    end

    always_comb begin
        gate_st = gin.bypass ? g_lat : g_q;
        clk_out = gin.bypass ? (clk & g_lat) : o_q;
        is_off  = gin.bypass ? !g_lat : (!g_q && !o_q);
    end

endmodule

// File: rtl/dualclk_gen.sv
module dualclk_gen
    import dualclk_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [PS_SEL_W-1:0] ps0_sel,
    input  logic [PS_SEL_W-1:0] ps1_sel,
    input  logic [RATIO_W-1:0]  ratio1,
    input  logic                pin_mode,
    input  logic [1:0]          reg_en,
    input  logic [1:0]          ctl_pin,
    output logic                clk_out0,
    output logic                clk_out1
);
    localparam int NUM_OUT = 2;

    logic [NUM_OUT-1:0] pin_s;
    logic [NUM_OUT-1:0] en;
    logic [NUM_OUT-1:0] req;
    logic [NUM_OUT-1:0] off;
    logic [NUM_OUT-1:0] gst;
    logic               pd_req;
    logic               halt;
    ctl_mode_e          mode;

    logic [PS_SEL_W-1:0] sel0_q, sel1_q;
    logic                tick0, tick1;
    logic                pslvl0, pslvl1;
    logic [RATIO_W-1:0]  ratio_q;
    logic [RATIO_W-1:0]  div_cnt;
    logic                div_lvl;
    gate_in_t            gin0, gin1;

    // Control pin synchronizers.
    for (genvar i = 0; i < NUM_OUT; i++) begin : g_sync
        logic [SYNC_STAGES-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst)
                sh_q <= '0;
            else
                sh_q <= {sh_q[SYNC_STAGES-2:0], ctl_pin[i]};
        end
        assign pin_s[i] = sh_q[SYNC_STAGES-1];
    end

    always_comb begin
        mode   = ctl_mode_e'(pin_mode);
        pd_req = (mode == CTL_AS_POWERDOWN) && pin_s[0];
        en     = (mode == CTL_AS_ENABLE) ? pin_s : reg_en;
        req    = en & {NUM_OUT{!pd_req}};
        // Counters stop only once both outputs have gone quiet.
        halt   = pd_req && (&off);
    end

    dualclk_prescaler u_ps0 (
        .clk    (clk),
        .rst    (rst),
        .clr    (halt),
        .sel_in (ps0_sel),
        .sel_q  (sel0_q),
        .tick   (tick0),
        .lvl    (pslvl0)
    );

    dualclk_prescaler u_ps1 (
        .clk    (clk),
        .rst    (rst),
        .clr    (halt),
        .sel_in (ps1_sel),
        .sel_q  (sel1_q),
        .tick   (tick1),
        .lvl    (pslvl1)
    );

    dualclk_ratio_div u_div (
        .clk      (clk),
        .rst      (rst),
        .clr      (halt),
        .tick     (tick1),
        .ratio_in (ratio1),
        .ratio_q  (ratio_q),
        .cnt_q    (div_cnt),
        .lvl      (div_lvl)
    );

    always_comb begin
        gin0.lvl    = pslvl0;
        gin0.bypass = (sel0_q == '0);
        gin0.req    = req[0];
        gin1.lvl    = (ratio_q == RATIO_W'(1)) ? pslvl1 : div_lvl;
        gin1.bypass = (sel1_q == '0) && (ratio_q == RATIO_W'(1));
        gin1.req    = req[1];
    end

    dualclk_out_gate u_gate0 (
        .clk     (clk),
        .rst     (rst),
        .gin     (gin0),
        .clk_out (clk_out0),
        .gate_st (gst[0]),
        .is_off  (off[0])
    );

    dualclk_out_gate u_gate1 (
        .clk     (clk),
        .rst     (rst),
        .gin     (gin1),
        .clk_out (clk_out1),
        .gate_st (gst[1]),
        .is_off  (off[1])
    );

endmodule

// File: rtl/dualclk_gen_chk.sv
module dualclk_gen_chk
    import dualclk_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [RATIO_W-1:0] ratio_q,
    input logic [RATIO_W-1:0] div_cnt,
    input logic               lvl0,
    input logic               lvl1,
    input logic               byp0,
    input logic               byp1,
    input logic               gst0,
    input logic               gst1,
    input logic               off0,
    input logic               off1,
    input logic               halt
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    assert_ratio_range_R3: assert property (@(posedge clk) disable iff (rst)
        (ratio_q >= RATIO_W'(1)) && (ratio_q <= RATIO_W'(RATIO_MAX)));

    assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
        div_cnt < ratio_q);

    assert_gate0_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(lvl0) && !byp0 && $past(!byp0)) |-> (gst0 == $past(gst0)));

    assert_gate1_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(lvl1) && !byp1 && $past(!byp1)) |-> (gst1 == $past(gst1)));

    assert_pd_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        halt |=> (!lvl0 && !lvl1));

    always_ff @(posedge clk) begin
        if (rst_d && !rst)
            assert_reset_off_R9: assert (off0 && off1);
    end

endmodule

bind dualclk_gen dualclk_gen_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .ratio_q (ratio_q),
    .div_cnt (div_cnt),
    .lvl0    (gin0.lvl),
    .lvl1    (gin1.lvl),
    .byp0    (gin0.bypass),
    .byp1    (gin1.bypass),
    .gst0    (gst[0]),
    .gst1    (gst[1]),
    .off0    (off[0]),
    .off1    (off[1]),
    .halt    (halt)
);

// File: tb/dualclk_gen_tb_top.sv
module dualclk_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  ps0_sel, ps1_sel;
    logic [10:0] ratio1;
    logic        pin_mode;
    logic [1:0]  reg_en, ctl_pin;
    logic        clk_out0, clk_out1;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;
    int  seed_v;

    always #4 clk = ~clk;

    dualclk_gen dut_i (
        .clk(clk), .rst(rst), .ps0_sel(ps0_sel), .ps1_sel(ps1_sel),
        .ratio1(ratio1), .pin_mode(pin_mode), .reg_en(reg_en),
        .ctl_pin(ctl_pin), .clk_out0(clk_out0), .clk_out1(clk_out1)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic smp();
        @(posedge clk);
        #1;
    endtask

    function automatic logic outk(input int k);
        return (k == 1) ? clk_out1 : clk_out0;
    endfunction

    function automatic int eff_n(input int r);
        if (r == 0) return 1;
        if (r > 1025) return 1025;
        return r;
    endfunction

    function automatic int hi0(input int s);
        return (s == 0) ? 0 : (1 << (s - 1));
    endfunction

    function automatic int per1(input int s, input int r);
        return eff_n(r) << s;
    endfunction

    function automatic int hi1(input int s, input int r);
        int n = eff_n(r);
        if (n == 1) return hi0(s);
        return (n >> 1) << s;
    endfunction

    // One full cycle: wait for low, then rise, count high, count low.
    task automatic measure(input int k, output int hi, output int lo);
        int t = 0;
        hi = 0;
        lo = 0;
        while (outk(k) !== 1'b0 && t < 20000) begin smp(); t++; end
        while (outk(k) !== 1'b1 && t < 40000) begin smp(); t++; end
        while (outk(k) === 1'b1 && t < 60000) begin smp(); t++; hi++; end
        while (outk(k) === 1'b0 && t < 80000) begin smp(); t++; lo++; end
    endtask

    task automatic low_win(input string tag, input int k, input int n);
        int bad = 0;
        repeat (n) begin
            smp();
            if (outk(k) !== 1'b0) bad++;
        end
        chk(tag, bad, 0);
    endtask

    task automatic pass_chk(input string tag, input int k);
        logic a, b;
        @(posedge clk); #2; a = outk(k);
        @(negedge clk); #2; b = outk(k);
        chk(tag, int'({a, b}), 2);
    endtask

    task automatic setcfg(input int s0, input int s1, input int r, input int settle);
        ps0_sel = 2'(s0);
        ps1_sel = 2'(s1);
        ratio1  = 11'(r);
        repeat (settle) smp();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int hi, lo, t, prev_w;
        seed_v   = $urandom(32'h5EED);
        rst      = 1'b1;
        ps0_sel  = 2'd2;
        ps1_sel  = 2'd1;
        ratio1   = 11'd3;
        pin_mode = 1'b0;
        reg_en   = 2'b00;
        ctl_pin  = 2'b11;
        repeat (4) smp();
        // R9: outputs low during reset
        chk("R9 out0 in reset", int'(clk_out0), 0);
        chk("R9 out1 in reset", int'(clk_out1), 0);
        rst = 1'b0;
        repeat (4) smp();

        // R1: prescaler 0 divide by 8
        setcfg(3, 1, 3, 20);
        measure(0, hi, lo);
        chk("R1 s0=3 high", hi, 4);
        chk("R1 s0=3 low", lo, 4);

        // R2: odd ratio duty and period
        setcfg(3, 2, 5, 40);
        measure(1, hi, lo);
        chk("R2 s1=2 n=5 high", hi, hi1(2, 5));
        chk("R2 s1=2 n=5 low", lo, per1(2, 5) - hi1(2, 5));

        // R3: clamping of the ratio field
        setcfg(3, 1, 0, 40);
        measure(1, hi, lo);
        chk("R3 ratio 0 high", hi, 1);
        chk("R3 ratio 0 low", lo, 1);
        setcfg(3, 0, 2047, 20);
        measure(1, hi, lo);
        chk("R3 ratio 2047 high", hi, 512);
        chk("R3 ratio 2047 low", lo, 513);
        setcfg(3, 0, 1026, 1100);
        measure(1, hi, lo);
        chk("R3 ratio 1026 period", hi + lo, 1025);

        // R8: pass-through on both paths
        setcfg(0, 0, 1, 1100);
        pass_chk("R8 out0 follows clk", 0);
        pass_chk("R8 out1 follows clk", 1);

        // Random settings, pins enabling both outputs
        prev_w = 20;
        for (int i = 0; i < 16; i++) begin
            int s0 = int'($urandom % 4);
            int s1 = int'($urandom % 4);
            int r  = int'($urandom % 41);
            setcfg(s0, s1, r, prev_w);
            prev_w = per1(s1, r) + 20;
            if (s0 == 0) pass_chk("R8 random out0", 0);
            else begin
                measure(0, hi, lo);
                chk("R1 random out0 high", hi, hi0(s0));
                chk("R1 random out0 low", lo, hi0(s0));
            end
            if (s1 == 0 && eff_n(r) == 1) pass_chk("R8 random out1", 1);
            else begin
                measure(1, hi, lo);
                chk("R2 random out1 high", hi, hi1(s1, r));
                chk("R2 random out1 low", lo, per1(s1, r) - hi1(s1, r));
            end
        end

        // R5: pin enables, register bits ignored
        setcfg(2, 1, 3, prev_w);
        pin_mode = 1'b0;
        reg_en   = 2'b11;
        ctl_pin  = 2'b10;
        repeat (20) smp();
        low_win("R5 R7 out0 off by pin", 0, 40);
        measure(1, hi, lo);
        chk("R5 out1 on by pin", hi, 2);
        reg_en  = 2'b00;
        ctl_pin = 2'b11;
        repeat (20) smp();
        measure(0, hi, lo);
        chk("R5 out0 on despite reg bit", hi, 2);

        // R6: register enables, pin 1 ignored, pin 0 powerdown
        pin_mode = 1'b1;
        reg_en   = 2'b01;
        ctl_pin  = 2'b10;
        repeat (20) smp();
        measure(0, hi, lo);
        chk("R6 out0 by reg bit, pin1 ignored", hi + lo, 4);
        low_win("R6 out1 off by reg bit", 1, 30);
        ctl_pin = 2'b11;
        repeat (20) smp();
        low_win("R6 R7 out0 powered down", 0, 40);
        // R10: release and restart
        ctl_pin = 2'b10;
        t = 0;
        while (clk_out0 !== 1'b1 && t < 100) begin smp(); t++; end
        chk("R10 first rise bound", int'(t <= 2 + 2 + 6), 1);
        hi = 0;
        while (clk_out0 === 1'b1 && hi < 100) begin smp(); hi++; end
        chk("R10 first pulse full", hi, 2);

        // R4: random enable toggling, every high run must be full
        pin_mode = 1'b0;
        begin
            int run0 = -1, run1 = -1, bad0 = 0, bad1 = 0;
            for (int i = 0; i < 1500; i++) begin
                smp();
                if ($urandom % 5 == 0) ctl_pin = 2'($urandom);
                if (clk_out0 === 1'b1) begin
                    if (run0 >= 0) run0++;
                end else begin
                    if (run0 > 0 && run0 != 2) bad0++;
                    run0 = 0;
                end
                if (clk_out1 === 1'b1) begin
                    if (run1 >= 0) run1++;
                end else begin
                    if (run1 > 0 && run1 != 2) bad1++;
                    run1 = 0;
                end
            end
            chk("R4 out0 no runt pulse", bad0, 0);
            chk("R4 out1 no runt pulse", bad1, 0);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule